// File: doc/BRIEF.md
# Half-Bridge Switching Modulator with Dead Time and Fault Latch

This block generates the gate-drive pair for one half-bridge leg of a digitally controlled power converter. A free-running counter sweeps from zero to a programmed terminal count. While the count is below the programmed on-time, the high-side phase is active; otherwise the low-side phase is active. Each side's turn-on is held back by a programmable number of clock cycles, so the two switches are never driven together. An on-time too short or too long to survive the dead time is snapped to a clean fully-off or fully-on drive with no sliver pulses.

The control firmware writes the on-time, terminal count, dead time and converter-sampling point at any moment. The block takes all four only when the counter wraps, so a period in progress is never disturbed. A one-cycle sampling strobe fires at the programmed count in every period, which lets the measurement of the output be placed at a fixed phase of the switching cycle. An overcurrent input turns both gates off at once, without waiting for a clock edge. It sets a sticky flag that firmware can clear only after the overcurrent has gone away.

Top module: `hb_pwm`

## Requirements
- R1: While reset is asserted, and after release until the first rising clock edge, `gate_hi`, `gate_lo`, `adc_trig` and `fault_latched` are all 0.
- R2: The counter runs from 0 up to the active terminal count P and then returns to 0, so one switching period lasts P+1 clock cycles; consecutive `adc_trig` pulses are exactly P+1 cycles apart.
- R3: With an active on-time D and dead time T where D > T and D+T < P+1, `gate_hi` is high for exactly D-T cycles of each period: the high-side phase covers counts below D, and its first T cycles are suppressed.
- R4: In the same case, `gate_lo` is high for exactly P+1-D-T cycles of each period. `gate_hi` and `gate_lo` are never high in the same cycle, and each side rises only after the other side has been low for at least one cycle when T > 0.
- R5: If D <= T, `gate_hi` stays low for the whole period and `gate_lo` stays high for the whole period.
- R6: If D > T and D+T >= P+1 (this includes D = P+1), `gate_hi` stays high for the whole period and `gate_lo` stays low for the whole period.
- R7: New values on `duty_in`, `period_in`, `dead_in` and `trig_in` take effect only on the clock edge at which the counter wraps from P to 0; a change made mid-period leaves that period's waveform unchanged.
- R8: A high level on `fault_in` drives both gates low and sets `fault_latched` at once, with no clock edge needed. Both gates stay low for as long as `fault_latched` is 1.
- R9: `fault_latched` clears only at a clock edge where `fault_clr` is 1 and `fault_in` is 0. A clear request while `fault_in` is high is ignored. After a clear, normal switching resumes.
- R10: `adc_trig` is high for one cycle in each period, in the cycle where the count equals the active `trig_in` value. It never fires when that value exceeds P. Its position is fixed relative to the high-side turn-on, which falls at count T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty_in | input | CNT_W | Requested high-side on-time in counts (shadowed) |
| period_in | input | CNT_W | Terminal count P; period is P+1 cycles (shadowed) |
| dead_in | input | DT_W | Dead time in clock cycles (shadowed) |
| trig_in | input | CNT_W | Count at which the sampling strobe fires (shadowed) |
| fault_in | input | 1 | Asynchronous overcurrent input, active high |
| fault_clr | input | 1 | Request to clear the fault latch |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| adc_trig | output | 1 | One-cycle converter start-of-conversion strobe |
| fault_latched | output | 1 | Sticky overcurrent flag |

## Verification
A counter or shadow register that is off by one shows up within one period as a wrong pulse width on one gate, or as a strobe spacing other than P+1. A dead-time timer that is not cleared or not saturated shows up as an overlap of the two gates, or as a sliver pulse near 0% or 100% duty, in the first period after the change. A fault latch that misbehaves can be seen at once: either gate stays on while the input is asserted, or it stays dark (or comes back too early) across the following period.

// File: rtl/hbp_pkg.sv
`timescale 1ns/1ps
package hbp_pkg;

  parameter int HBP_CNT_W = 8;
  parameter int HBP_DT_W  = 4;

  // Effective high-side phase length in counts after snapping to clean
  // fully-off or fully-on when the dead time would leave a sliver.
  function automatic int unsigned on_len(int unsigned duty,
                                         int unsigned term,
                                         int unsigned dead);
    int unsigned span;
    span = term + 1;
    if (duty <= dead)             return 0;
    else if (duty + dead >= span) return span;
    else                          return duty;
  endfunction

endpackage

// File: rtl/hbp_timebase.sv
`timescale 1ns/1ps
module hbp_timebase #(
  parameter int CNT_W = hbp_pkg::HBP_CNT_W,
  parameter int DT_W  = hbp_pkg::HBP_DT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] period_in,
  input  logic [DT_W-1:0]  dead_in,
  input  logic [CNT_W-1:0] trig_in,
  output logic             on_phase,
  output logic             adc_hit,
  output logic             running,
  output logic [DT_W-1:0]  dead_act
);
  localparam int ON_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, term_q, trig_q;
  logic [ON_W-1:0]  on_q;
  logic [DT_W-1:0]  dead_q;
  logic             run_q;
  logic             wrap;

  assign wrap = (cnt_q == term_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '0;
      trig_q <= '0;
      on_q   <= '0;
      dead_q <= '0;
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (wrap) begin
        cnt_q  <= '0;
        term_q <= period_in;
        trig_q <= trig_in;
        dead_q <= dead_in;
        on_q   <= ON_W'(hbp_pkg::on_len(32'(duty_in), 32'(period_in), 32'(dead_in)));
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign on_phase = ({1'b0, cnt_q} < on_q);
  assign adc_hit  = run_q && (cnt_q == trig_q);
  assign running  = run_q;
  assign dead_act = dead_q;

  // R2: count never passes the active terminal value
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);

  // R7: shadowed values only move on a wrap edge
  a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(on_q) && $stable(term_q) && $stable(dead_q) && $stable(trig_q)));

  // R10: strobe is a single cycle wide inside a period
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_hit && !wrap) |=> !adc_hit);

endmodule

// File: rtl/hbp_deadband.sv
`timescale 1ns/1ps
module hbp_deadband #(
  parameter int DT_W = hbp_pkg::HBP_DT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic            kill,
  input  logic [DT_W-1:0] dead,
  output logic            drive
);
  logic [DT_W-1:0] held_q;

  // cycles the phase has been requested, saturating at the dead time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             held_q <= '0;
    else if (kill || !want) held_q <= '0;
    else if (held_q < dead) held_q <= held_q + 1'b1;
  end

  assign drive = want && !kill && (held_q >= dead);

  // R4: a killed or idle side restarts its dead-time wait
  a_r4_timer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (kill || !want) |=> (held_q == '0));

endmodule

// File: rtl/hbp_fault.sv
`timescale 1ns/1ps
module hbp_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic clear,
  output logic latched
);
  always_ff @(posedge clk or negedge rst_n or posedge trip) begin
    if (!rst_n)     latched <= 1'b0;
    else if (trip)  latched <= 1'b1;
    else if (clear) latched <= 1'b0;
  end

  // R9: flag only drops on an explicit clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clear) |=> latched);

  // R9: clear is refused while the trip input is high
  a_r9_no_clear_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> latched);

endmodule

// File: rtl/hb_pwm.sv
`timescale 1ns/1ps
module hb_pwm #(
  parameter int CNT_W = hbp_pkg::HBP_CNT_W,
  parameter int DT_W  = hbp_pkg::HBP_DT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [CNT_W-1:0] period_in,
  input  logic [DT_W-1:0]  dead_in,
  input  logic [CNT_W-1:0] trig_in,
  input  logic             fault_in,
  input  logic             fault_clr,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             adc_trig,
  output logic             fault_latched
);
  localparam int SIDES = 2;

  logic             on_phase, adc_hit, running, kill;
  logic [DT_W-1:0]  dead_act;
  logic [SIDES-1:0] side_drive;

  hbp_timebase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_timebase (
    .clk(clk), .rst_n(rst_n),
    .duty_in(duty_in), .period_in(period_in), .dead_in(dead_in), .trig_in(trig_in),
    .on_phase(on_phase), .adc_hit(adc_hit), .running(running), .dead_act(dead_act)
  );

  hbp_fault u_fault (
    .clk(clk), .rst_n(rst_n), .trip(fault_in), .clear(fault_clr), .latched(fault_latched)
  );

  assign kill = fault_latched | fault_in;

  // side 0 follows the high-side phase, side 1 its complement
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    hbp_deadband #(.DT_W(DT_W)) u_band (
      .clk(clk), .rst_n(rst_n),
      .want((s == 0) ? on_phase : !on_phase),
      .kill(kill), .dead(dead_act), .drive(side_drive[s])
    );
  end

  assign gate_hi  = running && side_drive[0];
  assign gate_lo  = running && side_drive[1];
  assign adc_trig = adc_hit;

  // R4: complementary pair never overlaps
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R4: each turn-on follows an off cycle on the opposite side
  a_r4_gap_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) && dead_act != '0) |-> !$past(gate_lo));
  a_r4_gap_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_lo) && dead_act != '0) |-> !$past(gate_hi));

  // R8: latched fault keeps both switches dark
  a_r8_fault_dark: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> (!gate_hi && !gate_lo));

endmodule

// File: tb/hb_pwm_bench.sv
`timescale 1ns/1ps
module hb_pwm_bench;
  localparam int CW = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] duty_in = '0, period_in = '0, trig_in = '0;
  logic [DW-1:0] dead_in = '0;
  logic          fault_in = 1'b0, fault_clr = 1'b0;
  logic          gate_hi, gate_lo, adc_trig, fault_latched;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  hb_pwm #(.CNT_W(CW), .DT_W(DW)) u_hb_pwm (
    .clk(clk), .rst_n(rst_n), .duty_in(duty_in), .period_in(period_in),
    .dead_in(dead_in), .trig_in(trig_in), .fault_in(fault_in), .fault_clr(fault_clr),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .adc_trig(adc_trig), .fault_latched(fault_latched)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected per-period on-counts, derived from R3, R5 and R6
  function automatic int exp_hi(int d, int p, int t);
    if (d <= t) return 0;
    if (d + t >= p + 1) return p + 1;
    return d - t;
  endfunction
  function automatic int exp_lo(int d, int p, int t);
    if (d <= t) return p + 1;
    if (d + t >= p + 1) return 0;
    return p + 1 - d - t;
  endfunction

  task automatic program_cfg(input int d, input int p, input int t, input int tr);
    @(negedge clk);
    duty_in   = CW'(d);
    period_in = CW'(p);
    dead_in   = DW'(t);
    trig_in   = CW'(tr);
    repeat (600) @(negedge clk);
  endtask

  // sample two full periods and compare with the expected waveform
  task automatic measure(input int d, input int p, input int t, input int tr, input string tag);
    int span, hi_n, lo_n, tr_n, rise_n, ovl, tr_a, tr_b, rise_a, eh, el;
    bit prev_hi;
    span = p + 1;
    hi_n = 0; lo_n = 0; tr_n = 0; rise_n = 0; ovl = 0;
    tr_a = -1; tr_b = -1; rise_a = -1;
    @(negedge clk);
    prev_hi = gate_hi;
    for (int i = 0; i < 2 * span; i++) begin
      @(negedge clk);
      if (gate_hi) hi_n++;
      if (gate_lo) lo_n++;
      if (gate_hi && gate_lo) ovl++;
      if (gate_hi && !prev_hi) begin
        rise_n++;
        if (rise_a < 0) rise_a = i;
      end
      if (adc_trig) begin
        tr_n++;
        if (tr_a < 0) tr_a = i;
        else if (tr_b < 0) tr_b = i;
      end
      prev_hi = gate_hi;
    end
    eh = exp_hi(d, p, t);
    el = exp_lo(d, p, t);
    if (eh == 0)          check(hi_n == 0, {"R5 hi off ", tag}, hi_n, 0);
    else if (eh == span)  check(hi_n == 2 * span, {"R6 hi full ", tag}, hi_n, 2 * span);
    else                  check(hi_n == 2 * eh, {"R3 hi width ", tag}, hi_n, 2 * eh);
    check(lo_n == 2 * el, {"R4 lo width ", tag}, lo_n, 2 * el);
    check(ovl == 0, {"R4 overlap ", tag}, ovl, 0);
    if (tr > p) begin
      check(tr_n == 0, {"R10 no strobe ", tag}, tr_n, 0);
    end else begin
      check(tr_n == 2, {"R10 strobe count ", tag}, tr_n, 2);
      check(tr_b - tr_a == span, {"R2 period ", tag}, tr_b - tr_a, span);
      if (eh > 0 && eh < span) begin
        int ph_act, ph_exp;
        ph_act = (rise_a - tr_a + span) % span;
        ph_exp = (t - tr + span) % span;
        check(rise_n == 2, {"R3 one turn-on per period ", tag}, rise_n, 2);
        check(ph_act == ph_exp, {"R10 strobe phase ", tag}, ph_act, ph_exp);
      end
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int seed_sink;
    int cnt_hi;
    seed_sink = $urandom(32'd4242);

    // R1: reset state, with inputs that would turn the low side on
    duty_in = 8'd0; period_in = 8'd9; dead_in = 4'd0; trig_in = 8'd0;
    repeat (3) @(negedge clk);
    check(!gate_hi && !gate_lo && !adc_trig && !fault_latched, "R1 in reset",
          {28'd0, gate_hi, gate_lo, adc_trig, fault_latched}, 0);
    rst_n = 1'b1;
    #2;
    check(!gate_hi && !gate_lo && !adc_trig && !fault_latched, "R1 after release",
          {28'd0, gate_hi, gate_lo, adc_trig, fault_latched}, 0);

    // directed corners
    program_cfg(12, 40, 3, 5);    measure(12, 40, 3, 5, "mid");
    program_cfg(3, 20, 3, 2);     measure(3, 20, 3, 2, "R5 duty=dead");
    program_cfg(0, 20, 0, 7);     measure(0, 20, 0, 7, "R5 zero");
    program_cfg(19, 20, 2, 0);    measure(19, 20, 2, 0, "R6 near full");
    program_cfg(21, 20, 0, 20);   measure(21, 20, 0, 20, "R6 exact full");
    program_cfg(10, 30, 4, 200);  measure(10, 30, 4, 200, "R10 beyond period");
    program_cfg(5, 255, 15, 255); measure(5, 255, 15, 255, "longest");

    // constrained random
    for (int k = 0; k < 10; k++) begin
      int p, d, t, tr;
      p  = 1 + int'($urandom % 255);
      d  = int'($urandom % (p + 2));
      t  = int'($urandom % 16);
      tr = int'($urandom % 256);
      program_cfg(d, p, t, tr);
      measure(d, p, t, tr, "random");
    end

    // R7: mid-period duty write does not touch the running period
    program_cfg(30, 40, 2, 0);
    do @(negedge clk); while (!adc_trig);
    duty_in = 8'd10;
    cnt_hi = gate_hi ? 1 : 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gate_hi) cnt_hi++;
    end
    check(cnt_hi == 28, "R7 old duty held", cnt_hi, 28);
    cnt_hi = 0;
    for (int i = 0; i < 41; i++) begin
      @(negedge clk);
      if (gate_hi) cnt_hi++;
    end
    check(cnt_hi == 8, "R7 new duty at wrap", cnt_hi, 8);

    // R8: asynchronous shutdown, no clock edge needed
    @(negedge clk);
    #3 fault_in = 1'b1;
    #1;
    check(!gate_hi && !gate_lo, "R8 gates off at once", {30'd0, gate_hi, gate_lo}, 0);
    check(fault_latched, "R8 flag set at once", fault_latched, 1);
    @(negedge clk);
    fault_in = 1'b0;
    cnt_hi = 0;
    for (int i = 0; i < 82; i++) begin
      @(negedge clk);
      if (gate_hi || gate_lo) cnt_hi++;
    end
    check(cnt_hi == 0, "R8 dark while latched", cnt_hi, 0);
    check(fault_latched, "R9 sticky after input drops", fault_latched, 1);

    // R9: clear refused while input high
    fault_in = 1'b1; fault_clr = 1'b1;
    @(negedge clk);
    check(fault_latched, "R9 clear ignored in fault", fault_latched, 1);
    check(!gate_hi && !gate_lo, "R9 gates still off", {30'd0, gate_hi, gate_lo}, 0);
    fault_in = 1'b0;
    @(negedge clk);
    fault_clr = 1'b0;
    check(!fault_latched, "R9 cleared when input low", fault_latched, 0);
    repeat (200) @(negedge clk);
    measure(10, 40, 2, 0, "R9 resumed");

    finish_run();
  end
endmodule